// File: doc/BRIEF.md
# Modulo-24 Residue Unit

This block takes a 12-bit unsigned value and returns its remainder after division by 24 as a 5-bit result, one clock cycle after the value is presented. It does not build a general mod-24 divider. Instead it uses 24 = 3 * 8. The three least significant input bits are already the remainder modulo 8, so they pass straight to the low result field. The bits above them are reduced modulo 3, and that residue is placed above the low field.

The mod-3 reduction gives each upper input bit a two-bit weight: 2^k mod 3, which is 1 for even k and 2 for odd k. A balanced tree of small adders then combines these weights. Every adder adds two residues in the range 0..2, and it folds the sum back into that range whenever the sum reaches 3. No wide carry chain appears anywhere on the path.

The result and a valid flag are registered. The result register loads only on cycles that carry a valid input, so the last result stays on the output between valid inputs. Reset is synchronous and active high.

Top module: `mod24_reducer`

## Requirements
- R1: One cycle after a valid input, `res_q[2:0]` equals the input's bits 2..0. These result bits depend on no other input bit.
- R2: One cycle after a valid input, `res_q[4:3]` equals (input >> 3) mod 3. The whole `res_q` therefore equals the input mod 24.
- R3: The upper field `res_q[4:3]` only ever holds 0, 1 or 2. The code 3 never appears there.
- R4: `vld_q` in each cycle equals `vld_in` of the previous cycle, giving a latency of exactly one clock.
- R5: A cycle with `vld_in` low leaves `res_q` unchanged. The last valid result is held.
- R6: While `rst` is high at a clock edge, `vld_q` and `res_q` are cleared to 0 at that edge.
- R7: The extreme inputs map correctly: 0 gives 0, 23 gives 23, 24 gives 0, and 4095 gives 15 (upper field 1, low field 7).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| vld_in | input | 1 | Marks `x_in` as a value to reduce this cycle |
| x_in | input | 12 | Unsigned value to reduce |
| vld_q | output | 1 | Registered copy of `vld_in`, one cycle late |
| res_q | output | 5 | Registered remainder mod 24: {mod-3 residue of bits 11..3, bits 2..0} |

## Verification
The assertions take for granted that `x_in` holds known bit values whenever `vld_in` is high. They also take for granted that `rst` is applied synchronously, for at least one full clock. Their `$past` terms depend on both of these. The stimulus changes inputs only on the falling clock edge, keeps `vld_in` low during reset, and draws every value from the 12-bit range. The stimulus first walks all 4096 inputs back to back. It then mixes seeded random values with idle cycles, so the hold behaviour is exercised between valid inputs.

// File: rtl/mod24_pkg.sv
package mod24_pkg;

  // A mod-3 residue is always 0, 1 or 2, so it fits in two bits.
  typedef logic [1:0] res3_t;

  // Adds two mod-3 residues and folds the sum back into the range 0..2.
  function automatic res3_t add_mod3(input res3_t a, input res3_t b);
    logic [2:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= 3'd3) s = s - 3'd3;
    return s[1:0];
  endfunction

  // Weight of bit position pos, taken modulo 3: 2^pos mod 3 is 1 or 2.
  function automatic res3_t weight_mod3(input int unsigned pos);
    return (pos % 2 == 0) ? 2'd1 : 2'd2;
  endfunction

endpackage

// File: rtl/m24_leaf_residue.sv
// Maps every upper input bit to its weighted two-bit residue.
module m24_leaf_residue
  import mod24_pkg::*;
#(
  parameter int N = 9
) (
  input  logic [N-1:0]   bits_in,
  output logic [2*N-1:0] leaf_flat
);

  for (genvar k = 0; k < N; k++) begin : g_leaf
    assign leaf_flat[2*k +: 2] = bits_in[k] ? weight_mod3(k) : 2'd0;
  end

endmodule

// File: rtl/m24_mod3_tree.sv
// Balanced tree of folding mod-3 adders. Unused leaves are tied to zero.
module m24_mod3_tree
  import mod24_pkg::*;
#(
  parameter int N = 9
) (
  input  logic [2*N-1:0] leaf_flat,
  output res3_t          total
);

  localparam int LEVELS = (N > 1) ? $clog2(N) : 0;
  localparam int LEAVES = 1 << LEVELS;

  for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
    localparam int W = LEAVES >> l;
    res3_t s [W];
    if (l == 0) begin : g_in
      for (genvar i = 0; i < W; i++) begin : g_n
        if (i < N) begin : g_use
          assign s[i] = leaf_flat[2*i +: 2];
        end else begin : g_pad
          assign s[i] = 2'd0;
        end
      end
    end else begin : g_sum
      for (genvar i = 0; i < W; i++) begin : g_n
        assign s[i] = add_mod3(g_lvl[l-1].s[2*i], g_lvl[l-1].s[2*i+1]);
      end
    end
  end

  assign total = g_lvl[LEVELS].s[0];

endmodule

// File: rtl/m24_out_reg.sv
// Output stage: a valid flag and a result that loads only on valid cycles.
module m24_out_reg #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         vld_d,
  input  logic [W-1:0] res_d,
  output logic         vld_q,
  output logic [W-1:0] res_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (vld_d) res_q <= res_d;
    end
  end

endmodule

// File: rtl/mod24_reducer.sv
// Reduces x_in modulo (3 << LOW_W); with the defaults that modulus is 24.
module mod24_reducer
  import mod24_pkg::*;
#(
  parameter int IN_W  = 12,
  parameter int LOW_W = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 vld_in,
  input  logic [IN_W-1:0]      x_in,
  output logic                 vld_q,
  output logic [LOW_W+1:0]     res_q
);

  localparam int HI_W  = IN_W - LOW_W;
  localparam int OUT_W = LOW_W + 2;

  logic [2*HI_W-1:0] leaf_flat;
  res3_t             hi_res;
  logic [OUT_W-1:0]  res_d;

  m24_leaf_residue #(.N(HI_W)) u_leaf (
    .bits_in   (x_in[IN_W-1:LOW_W]),
    .leaf_flat (leaf_flat)
  );

  m24_mod3_tree #(.N(HI_W)) u_tree (
    .leaf_flat (leaf_flat),
    .total     (hi_res)
  );

  // The low field is wired straight through, so it never sees an upper bit.
  assign res_d = {hi_res, x_in[LOW_W-1:0]};

  m24_out_reg #(.W(OUT_W)) u_out (
    .clk   (clk),
    .rst   (rst),
    .vld_d (vld_in),
    .res_d (res_d),
    .vld_q (vld_q),
    .res_q (res_q)
  );

endmodule

// File: rtl/mod24_reducer_chk.sv
module mod24_reducer_chk #(
  parameter int IN_W  = 12,
  parameter int LOW_W = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               vld_in,
  input logic [IN_W-1:0]    x_in,
  input logic               vld_q,
  input logic [LOW_W+1:0]   res_q
);

  localparam int OUT_W = LOW_W + 2;

  // Set from the first clock edge onward, so no check compares against
  // values sampled before that edge.
  logic started = 1'b0;
  always_ff @(posedge clk) started <= 1'b1;

  assert_low_pass_R1: assert property (@(posedge clk) disable iff (rst || !started)
    vld_in |=> res_q[LOW_W-1:0] == $past(x_in[LOW_W-1:0]));

  assert_upper_mod3_R2: assert property (@(posedge clk) disable iff (rst || !started)
    vld_in |=> res_q[OUT_W-1 -: 2] == 2'(($past(x_in) >> LOW_W) % 3));

  assert_no_code3_R3: assert property (@(posedge clk) disable iff (rst)
    res_q[OUT_W-1 -: 2] != 2'b11);

  assert_valid_follow_R4: assert property (@(posedge clk) disable iff (rst || !started)
    vld_in |=> vld_q);

  assert_valid_drop_R4: assert property (@(posedge clk) disable iff (rst || !started)
    !vld_in |=> !vld_q);

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst || !started)
    !vld_in |=> $stable(res_q));

endmodule

bind mod24_reducer mod24_reducer_chk #(.IN_W(IN_W), .LOW_W(LOW_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .vld_in (vld_in),
  .x_in   (x_in),
  .vld_q  (vld_q),
  .res_q  (res_q)
);

// File: tb/mod24_reducer_bench.sv
`timescale 1ns/1ps
module mod24_reducer_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        vld_in = 1'b0;
  logic [11:0] x_in = '0;
  logic        vld_q;
  logic [4:0]  res_q;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;
  logic [4:0] last_exp = '0;

  always #2.5 clk = ~clk;

  mod24_reducer u_mod24_reducer (
    .clk(clk), .rst(rst), .vld_in(vld_in), .x_in(x_in),
    .vld_q(vld_q), .res_q(res_q)
  );

  function automatic logic [4:0] exp_mod24(input logic [11:0] x);
    return 5'(int'(x) % 24);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Present one input at the falling edge, then check the result one
  // falling edge later, after the capturing rising edge.
  task automatic step(input logic v, input logic [11:0] x);
    vld_in = v;
    x_in   = x;
    @(posedge clk);
    @(negedge clk);
    check("R4 valid", int'(vld_q), int'(v));
    if (v) begin
      last_exp = exp_mod24(x);
      check("R1 low field", int'(res_q[2:0]), int'(x[2:0]));
      check("R2 upper field", int'(res_q[4:3]), int'(x >> 3) % 3);
    end else begin
      check("R5 hold", int'(res_q), int'(last_exp));
    end
    check("R3 no code 3", int'(res_q[4:3] == 2'b11), 0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    vld_in = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R6 reset valid", int'(vld_q), 0);
    check("R6 reset result", int'(res_q), 0);
    last_exp = '0;
    rst = 1'b0;
  endtask

  task automatic corner(input logic [11:0] x, input int exp);
    step(1'b1, x);
    check("R7 corner", int'(res_q), exp);
  endtask

  initial begin
    void'($urandom(32'd7741));
    @(negedge clk);
    @(negedge clk);
    do_reset();
    // R1 R2 R3 R4: exhaustive walk over every input value
    for (int i = 0; i < 4096; i++) step(1'b1, 12'(i));
    // R5: idle cycles hold the last result (4095 mod 24)
    step(1'b0, 12'h000);
    step(1'b0, 12'h5A5);
    // R7: directed extremes
    corner(12'd0, 0);
    corner(12'd23, 23);
    corner(12'd24, 0);
    corner(12'd4095, 15);
    corner(12'd4088, 8);
    // Random mix of valid and idle cycles
    for (int i = 0; i < 3000; i++) begin
      logic v;
      v = ($urandom % 4) != 0;
      step(v, 12'($urandom % 4096));
    end
    // R6: reset in mid-stream after a nonzero result
    corner(12'd4095, 15);
    do_reset();
    step(1'b0, 12'hFFF);
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule